// File: doc/BRIEF.md
# DMA Channel Fault Recorder

This block watches one DMA channel for rule violations and records them. The channel's datapath sends it strobes and values as work proceeds: descriptor fetches with their length and control fields, the first fetch of a chain, writes to the channel command register, source-read and destination-write failures, parity errors reported by the chipset, interrupt attempts and completion-address use. The recorder applies fixed validity checks to these inputs. Each failure sets a sticky bit in a 16-bit fault register.

Software clears the fault register by writing 1s to the bits it wants to clear. For the data-path faults (source, destination and parity), the address of the failing descriptor is latched. That address stays valid until software has cleared every data-path bit. A single summary output shows whether any fault bit is set.

The block does not move data, fetch descriptors, raise interrupts or decode addresses. It only receives the results of that logic as inputs.

Top module: `dma_fault_log`

## Requirements
- R1: After reset, `fault_reg` is 0, `fault_addr` is 0 and `fault_any` is 0.
- R2: Bits 15, 14 and 7 and bits 2:0 of `fault_reg` always read 0, even when every event fires at once and when software writes 1s to those bits.
- R3: Bit 13 sets in the cycle after `irq_try` is high while `irq_cfg_ok` is low.
- R4: Bit 12 sets in the cycle after `cmpl_use` is high while `cmpl_addr_ok` is low.
- R5: Bit 11 sets when `desc_vld` is high and `desc_len` is either 0 or greater than `xfer_max`. A length equal to `xfer_max` is legal.
- R6: Bit 10 sets when `desc_vld` is high and `desc_ctrl` has a bit set outside `CTRL_LEGAL` (default 8'h3F, so bits 7:6 are illegal).
- R7: Bit 9 sets on `dst_fail`, and bit 8 sets on `src_fail`.
- R8: `par_err` sets bit 6. It also sets bit 8 when `par_dst` is 0 (source data) or bit 9 when `par_dst` is 1 (destination data).
- R9: Bit 5 sets when `cmd_wr` is high and `cmd_val` has two or more bits set. A value of zero, or one with exactly one bit set, is legal.
- R10: Bit 4 sets when `chain_go` is high and either `chain_ok` is low or `chain_lo` (the low 6 address bits) is nonzero.
- R11: Bit 3 sets on `desc_misc`.
- R12: Every implemented bit is sticky. It clears only when `clr_wr` is high and the matching bit of `clr_val` is 1. An event on the same bit in the same cycle as its clear leaves the bit set.
- R13: `fault_any` is high exactly when any bit of `fault_reg` is set.
- R14: A data-path fault (bit 6, 8 or 9 being set) latches `xfer_addr` into `fault_addr`, but only when none of bits 9, 8 and 6 is set. While any of those bits stays set, `fault_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_vld | input | 1 | Descriptor fetched this cycle |
| desc_len | input | LEN_W | Transfer length of the fetched descriptor |
| desc_ctrl | input | CTRL_W | Control field of the fetched descriptor |
| xfer_max | input | LEN_W | Programmed maximum transfer length |
| chain_go | input | 1 | First descriptor of a chain is being fetched |
| chain_lo | input | ALIGN_W | Low bits of the chain start address |
| chain_ok | input | 1 | Address decoder accepts the chain start address |
| cmd_wr | input | 1 | Write to the channel command register |
| cmd_val | input | CMD_W | Value written to the command register |
| src_fail | input | 1 | Source read failed |
| dst_fail | input | 1 | Destination write failed |
| par_err | input | 1 | Chipset reported a data parity error |
| par_dst | input | 1 | Parity error side: 0 is source, 1 is destination |
| xfer_addr | input | AW | Address of the descriptor in progress |
| irq_try | input | 1 | Channel attempts an interrupt |
| irq_cfg_ok | input | 1 | Interrupt configuration is valid |
| cmpl_use | input | 1 | Completion address is used for a status update |
| cmpl_addr_ok | input | 1 | Completion address is configured and legal |
| desc_misc | input | 1 | Descriptor fault not covered by any other bit |
| clr_wr | input | 1 | Software write-1-to-clear strobe |
| clr_val | input | 16 | Bits to clear |
| fault_reg | output | 16 | Sticky fault register |
| fault_addr | output | AW | Latched address of the failing descriptor |
| fault_any | output | 1 | OR of all fault bits |

## Verification
The assertions assume that the strobes and their qualifying values are sampled in the same cycle. They also assume that the inputs are known from the first clock after reset, and that no event is counted before that point. The bench drives every input to an idle zero during reset. It changes inputs only on the falling edge and returns every strobe to zero after one cycle, so each event lasts exactly one cycle. Events that happen together (a parity error beside a clear, or all events at once) are driven deliberately in the same cycle, so the set-over-clear and capture-hold cases are each tested in one known cycle.

// File: rtl/dma_fault_pkg.sv
`timescale 1ns/1ps
package dma_fault_pkg;
  localparam int FR_W = 16;
  localparam int B_IRQ   = 13;
  localparam int B_CMPL  = 12;
  localparam int B_LEN   = 11;
  localparam int B_CTRL  = 10;
  localparam int B_DST   = 9;
  localparam int B_SRC   = 8;
  localparam int B_PAR   = 6;
  localparam int B_CMD   = 5;
  localparam int B_CHAIN = 4;
  localparam int B_MISC  = 3;
  localparam logic [FR_W-1:0] IMPL_MASK = 16'h3F78;
  localparam logic [FR_W-1:0] DATA_MASK = 16'h0340;
endpackage

// File: rtl/dma_fault_detect.sv
`timescale 1ns/1ps
module dma_fault_detect
  import dma_fault_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int CTRL_W = 8,
  parameter int CMD_W = 8,
  parameter int ALIGN_W = 6,
  parameter logic [CTRL_W-1:0] CTRL_LEGAL = 8'h3F
) (
  input  logic              desc_vld,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [CTRL_W-1:0] desc_ctrl,
  input  logic [LEN_W-1:0]  xfer_max,
  input  logic              chain_go,
  input  logic [ALIGN_W-1:0] chain_lo,
  input  logic              chain_ok,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_val,
  input  logic              src_fail,
  input  logic              dst_fail,
  input  logic              par_err,
  input  logic              par_dst,
  input  logic              irq_try,
  input  logic              irq_cfg_ok,
  input  logic              cmpl_use,
  input  logic              cmpl_addr_ok,
  input  logic              desc_misc,
  output logic [FR_W-1:0]   evt,
  output logic              data_evt
);
  function automatic logic len_bad(input logic [LEN_W-1:0] len, input logic [LEN_W-1:0] cap);
    return (len == '0) || (len > cap);
  endfunction

  function automatic logic multi_hot(input logic [CMD_W-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction

  function automatic logic ctrl_bad(input logic [CTRL_W-1:0] c);
    return (c & ~CTRL_LEGAL) != '0;
  endfunction

  logic src_side, dst_side;
  assign src_side = src_fail | (par_err & ~par_dst);
  assign dst_side = dst_fail | (par_err &  par_dst);

  always_comb begin
    evt = '0;
    evt[B_IRQ]   = irq_try & ~irq_cfg_ok;
    evt[B_CMPL]  = cmpl_use & ~cmpl_addr_ok;
    evt[B_LEN]   = desc_vld & len_bad(desc_len, xfer_max);
    evt[B_CTRL]  = desc_vld & ctrl_bad(desc_ctrl);
    evt[B_DST]   = dst_side;
    evt[B_SRC]   = src_side;
    evt[B_PAR]   = par_err;
    evt[B_CMD]   = cmd_wr & multi_hot(cmd_val);
    evt[B_CHAIN] = chain_go & (~chain_ok | (chain_lo != '0));
    evt[B_MISC]  = desc_misc;
  end

  assign data_evt = src_side | dst_side;
endmodule

// File: rtl/dma_fault_bank.sv
`timescale 1ns/1ps
module dma_fault_bank
  import dma_fault_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FR_W-1:0] evt,
  input  logic            clr_wr,
  input  logic [FR_W-1:0] clr_val,
  output logic [FR_W-1:0] q
);
  logic [FR_W-1:0] clr_eff, keep, nxt;
  assign clr_eff = clr_wr ? clr_val : '0;
  assign keep    = q & ~clr_eff;
  assign nxt     = (keep | evt) & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R12: bits not cleared stay set
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(keep)) == $past(keep)));
  // R12: an event sets its bit even against a clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((q & $past(evt)) == $past(evt)));
  // R12: no bit rises without an event
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q) & ~$past(evt)) == '0));
endmodule

// File: rtl/dma_fault_addr.sv
`timescale 1ns/1ps
module dma_fault_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_evt,
  input  logic          data_held,
  input  logic [AW-1:0] xfer_addr,
  output logic [AW-1:0] fault_addr
);
  logic grab;
  assign grab = data_evt & ~data_held;

  always_ff @(posedge clk) begin
    if (!rst_n)    fault_addr <= '0;
    else if (grab) fault_addr <= xfer_addr;
  end

  // R14: first data-path fault captures the address
  a_r14_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && !data_held) |=> (fault_addr == $past(xfer_addr)));
  // R14: address holds while a data-path bit is set
  a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
    data_held |=> $stable(fault_addr));
endmodule

// File: rtl/dma_fault_log.sv
`timescale 1ns/1ps
module dma_fault_log
  import dma_fault_pkg::*;
#(
  parameter int AW = 32,
  parameter int LEN_W = 24,
  parameter int CTRL_W = 8,
  parameter int CMD_W = 8,
  parameter int ALIGN_W = 6,
  parameter logic [CTRL_W-1:0] CTRL_LEGAL = 8'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_vld,
  input  logic [LEN_W-1:0]   desc_len,
  input  logic [CTRL_W-1:0]  desc_ctrl,
  input  logic [LEN_W-1:0]   xfer_max,
  input  logic               chain_go,
  input  logic [ALIGN_W-1:0] chain_lo,
  input  logic               chain_ok,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_val,
  input  logic               src_fail,
  input  logic               dst_fail,
  input  logic               par_err,
  input  logic               par_dst,
  input  logic [AW-1:0]      xfer_addr,
  input  logic               irq_try,
  input  logic               irq_cfg_ok,
  input  logic               cmpl_use,
  input  logic               cmpl_addr_ok,
  input  logic               desc_misc,
  input  logic               clr_wr,
  input  logic [15:0]        clr_val,
  output logic [15:0]        fault_reg,
  output logic [AW-1:0]      fault_addr,
  output logic               fault_any
);
  logic [FR_W-1:0] evt;
  logic            data_evt;
  logic            data_held;

  dma_fault_detect #(
    .LEN_W(LEN_W), .CTRL_W(CTRL_W), .CMD_W(CMD_W),
    .ALIGN_W(ALIGN_W), .CTRL_LEGAL(CTRL_LEGAL)
  ) u_detect (
    .desc_vld(desc_vld), .desc_len(desc_len), .desc_ctrl(desc_ctrl),
    .xfer_max(xfer_max), .chain_go(chain_go), .chain_lo(chain_lo),
    .chain_ok(chain_ok), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
    .src_fail(src_fail), .dst_fail(dst_fail), .par_err(par_err),
    .par_dst(par_dst), .irq_try(irq_try), .irq_cfg_ok(irq_cfg_ok),
    .cmpl_use(cmpl_use), .cmpl_addr_ok(cmpl_addr_ok),
    .desc_misc(desc_misc), .evt(evt), .data_evt(data_evt)
  );

  dma_fault_bank u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .clr_wr(clr_wr), .clr_val(clr_val), .q(fault_reg)
  );

  assign data_held = (fault_reg & DATA_MASK) != '0;

  dma_fault_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .data_evt(data_evt),
    .data_held(data_held), .xfer_addr(xfer_addr), .fault_addr(fault_addr)
  );

  assign fault_any = fault_reg != '0;

  // R8: source-side parity sets both parity and source bits
  a_r8_par_src: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !par_dst) |=> (fault_reg[B_PAR] && fault_reg[B_SRC]));
  // R8: destination-side parity sets both parity and destination bits
  a_r8_par_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && par_dst) |=> (fault_reg[B_PAR] && fault_reg[B_DST]));
endmodule

// File: tb/sim_dma_fault_log.sv
`timescale 1ns/1ps
module sim_dma_fault_log;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        desc_vld = 0;
  logic [23:0] desc_len = 0;
  logic [7:0]  desc_ctrl = 0;
  logic [23:0] xfer_max = 24'd100;
  logic        chain_go = 0;
  logic [5:0]  chain_lo = 0;
  logic        chain_ok = 1;
  logic        cmd_wr = 0;
  logic [7:0]  cmd_val = 0;
  logic        src_fail = 0, dst_fail = 0, par_err = 0, par_dst = 0;
  logic [31:0] xfer_addr = 0;
  logic        irq_try = 0, irq_cfg_ok = 1, cmpl_use = 0, cmpl_addr_ok = 1;
  logic        desc_misc = 0, clr_wr = 0;
  logic [15:0] clr_val = 0;
  logic [15:0] fault_reg;
  logic [31:0] fault_addr;
  logic        fault_any;

  dma_fault_log u0 (.*);

  typedef struct { logic [15:0] st; logic [31:0] ad; logic an; string tag; } item_t;
  item_t exp_q[$];
  logic [15:0] m_st = 0;
  logic [31:0] m_ad = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic idle();
    desc_vld = 0; chain_go = 0; cmd_wr = 0; src_fail = 0; dst_fail = 0;
    par_err = 0; irq_try = 0; cmpl_use = 0; desc_misc = 0; clr_wr = 0;
  endtask

  // driver: reference model from the requirements, then push expectation
  task automatic apply(input string tag);
    logic [15:0] e;
    item_t it;
    e = 0;
    if (irq_try && irq_cfg_ok == 0) e[13] = 1;
    if (cmpl_use && cmpl_addr_ok == 0) e[12] = 1;
    if (desc_vld && (desc_len == 0 || desc_len > xfer_max)) e[11] = 1;
    if (desc_vld && desc_ctrl[7:6] != 0) e[10] = 1;
    if (dst_fail || (par_err && par_dst)) e[9] = 1;
    if (src_fail || (par_err && !par_dst)) e[8] = 1;
    if (par_err) e[6] = 1;
    if (cmd_wr && $countones(cmd_val) > 1) e[5] = 1;
    if (chain_go && (!chain_ok || chain_lo != 0)) e[4] = 1;
    if (desc_misc) e[3] = 1;
    if ((e[9] || e[8]) && m_st[9] == 0 && m_st[8] == 0 && m_st[6] == 0) m_ad = xfer_addr;
    if (clr_wr) m_st = m_st & ~clr_val;
    m_st = m_st | e;
    it.st = m_st; it.ad = m_ad; it.an = (m_st != 0); it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    idle();
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_val = 16'hFFFF; apply("R12");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_cmp++;
        if (fault_reg !== it.st || fault_addr !== it.ad || fault_any !== it.an) begin
          n_bad++;
          $display("FAIL %s (R13 any): reg=%h addr=%h any=%b expected reg=%h addr=%h any=%b",
                   it.tag, fault_reg, fault_addr, fault_any, it.st, it.ad, it.an);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    apply("R1");                                   // reset state
    irq_try = 1; irq_cfg_ok = 1; apply("R3");      // valid config: no fault
    irq_try = 1; irq_cfg_ok = 0; apply("R3");
    irq_cfg_ok = 1; clear_all();
    cmpl_use = 1; apply("R4");                     // ok address
    cmpl_use = 1; cmpl_addr_ok = 0; apply("R4");
    cmpl_addr_ok = 1; clear_all();
    desc_vld = 1; desc_len = 24'd100; apply("R5"); // equal to max: legal
    desc_vld = 1; desc_len = 24'd0; apply("R5");
    clear_all();
    desc_vld = 1; desc_len = 24'd101; apply("R5");
    clear_all();
    desc_vld = 1; desc_len = 24'd5; desc_ctrl = 8'h3F; apply("R6");
    desc_vld = 1; desc_ctrl = 8'h40; apply("R6");
    desc_ctrl = 0; clear_all();
    cmd_wr = 1; cmd_val = 8'h00; apply("R9");
    cmd_wr = 1; cmd_val = 8'h04; apply("R9");
    cmd_wr = 1; cmd_val = 8'h05; apply("R9");
    clear_all();
    chain_go = 1; chain_lo = 6'h00; apply("R10");
    chain_go = 1; chain_lo = 6'h20; apply("R10");
    clear_all();
    chain_go = 1; chain_lo = 6'h00; chain_ok = 0; apply("R10");
    chain_ok = 1; clear_all();
    desc_misc = 1; apply("R11");
    clear_all();
    // data path and address capture
    src_fail = 1; xfer_addr = 32'h1000_0040; apply("R7 R14");
    dst_fail = 1; xfer_addr = 32'h2000_0080; apply("R7 R14");   // hold first address
    clr_wr = 1; clr_val = 16'h0100; apply("R14");                // bit 9 still set
    src_fail = 1; xfer_addr = 32'h3000_0000; apply("R14");       // still held
    clr_wr = 1; clr_val = 16'h0300; apply("R14");
    src_fail = 1; xfer_addr = 32'h4000_0000; apply("R14");       // new capture
    clear_all();
    par_err = 1; par_dst = 0; xfer_addr = 32'h5000_0000; apply("R8");
    clear_all();
    par_err = 1; par_dst = 1; xfer_addr = 32'h6000_0000; apply("R8");
    // set wins over clear in the same cycle
    par_err = 1; par_dst = 1; clr_wr = 1; clr_val = 16'h0240; apply("R12");
    clear_all();
    desc_misc = 1; apply("R12");
    apply("R12");                                               // sticky with no clear
    clr_wr = 1; clr_val = 16'h0010; apply("R12");               // clearing another bit
    // every event at once, then write 1s everywhere
    irq_try = 1; irq_cfg_ok = 0; cmpl_use = 1; cmpl_addr_ok = 0;
    desc_vld = 1; desc_len = 0; desc_ctrl = 8'hC0; src_fail = 1; dst_fail = 1;
    par_err = 1; cmd_wr = 1; cmd_val = 8'hFF; chain_go = 1; chain_lo = 6'h3F;
    desc_misc = 1; xfer_addr = 32'h7000_0000; apply("R2");
    irq_cfg_ok = 1; cmpl_addr_ok = 1; desc_ctrl = 0; chain_lo = 0; cmd_val = 0;
    clear_all();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule